// File: doc/BRIEF.md
# Dual-Device Memory Address Decoder

This block turns a 32-bit CPU address into chip selects for two memory devices. Each device holds 1M locations and has 20 address lines. Both devices are wired to the same low 20 address bits. Without chip-select logic they would both answer every access, so the decoder looks at the upper address bits and chooses which device, if either, responds. The low 20 bits go out unchanged as the local address that both devices share.

A static parameter picks one of two schemes.

- **Cheap scheme.** Only the top address line is used. One device answers when that line is low and the other when it is high. One device is therefore always selected, and every device location repeats many times across the 4G space.
- **Unique scheme.** Every upper bit is compared against a parameterised base. Each device location then appears at exactly one CPU address, and addresses outside the two windows select nothing.

The logic has no registers. The selects follow the address within the same cycle.

Top module: `mem_addr_decoder`

## Requirements
- R1: `local_addr_o` always equals `addr_i[19:0]`, in both modes.
- R2: In partial mode (`MODE = DEC_PARTIAL`), `sel_dev1_o` is 1 exactly when `addr_i[31]` is 1, and `sel_dev0_o` is 1 exactly when `addr_i[31]` is 0.
- R3: In partial mode, exactly one of the two selects is 1 for every address.
- R4: In partial mode, `addr_i[30:20]` have no effect. Two addresses that differ only in those bits give the same selects and the same local address.
- R5: In full mode (`MODE = DEC_FULL`), `sel_dev0_o` is 1 only when `addr_i[31:21]` equals `BASE` and `addr_i[20]` is 0.
- R6: In full mode, `sel_dev1_o` is 1 only when `addr_i[31:21]` equals `BASE` and `addr_i[20]` is 1.
- R7: In full mode, any address whose bits [31:21] differ from `BASE` leaves both selects at 0.
- R8: The two selects are never 1 together, in either mode.
- R9: The outputs hold no state. A change on `addr_i` appears on the outputs in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | 32 | CPU address bus |
| sel_dev0_o | output | 1 | Active-high select for memory device 0 |
| sel_dev1_o | output | 1 | Active-high select for memory device 1 |
| local_addr_o | output | 20 | Location within the selected device |

## Verification
The hardest cases to reach are the full-mode window edges. An address can look almost in range and still be rejected: it can differ from the base in one high bit only, or sit just below or just above the two 1M windows. The stimulus table places addresses on both sides of each edge (`0x7FFF_FFFF`, `0x8000_0000`, `0x801F_FFFF`, `0x8020_0000`) and includes one address that differs from the base only in bit 30. Aliasing in partial mode is shown by sweeping bits 30:20 while the low bits stay fixed. The check is that the selects and the local address do not move.

// File: rtl/mad_pkg.sv
package mad_pkg;

    typedef enum logic {
        DEC_PARTIAL = 1'b0,
        DEC_FULL    = 1'b1
    } dec_mode_e;

    typedef struct packed {
        logic dev1;
        logic dev0;
    } chip_sel_t;

    localparam chip_sel_t SEL_NONE = '{dev1: 1'b0, dev0: 1'b0};

    function automatic chip_sel_t pick_by_bit(input logic b);
        chip_sel_t s;
        s.dev1 = b;
        s.dev0 = ~b;
        return s;
    endfunction

    function automatic chip_sel_t gate_sel(input chip_sel_t s, input logic en);
        chip_sel_t r;
        r.dev1 = s.dev1 & en;
        r.dev0 = s.dev0 & en;
        return r;
    endfunction

endpackage

// File: rtl/mad_partial_dec.sv
module mad_partial_dec (
    input  logic                msb_i,
    output mad_pkg::chip_sel_t  sel_o
);
    always_comb begin
        sel_o = mad_pkg::pick_by_bit(msb_i);
    end
endmodule

// File: rtl/mad_full_dec.sv
module mad_full_dec #(
    parameter int TAG_W = 11,
    parameter logic [TAG_W-1:0] BASE = '0
) (
    input  logic [TAG_W-1:0]    tag_i,
    input  logic                bank_i,
    output mad_pkg::chip_sel_t  sel_o
);
    logic hit;

    always_comb begin
        hit   = (tag_i == BASE);
        sel_o = mad_pkg::gate_sel(mad_pkg::pick_by_bit(bank_i), hit);
    end
endmodule

// File: rtl/mem_addr_decoder.sv
module mem_addr_decoder #(
    parameter int ADDR_W = 32,
    parameter int LOCAL_W = 20,
    parameter mad_pkg::dec_mode_e MODE = mad_pkg::DEC_FULL,
    parameter logic [ADDR_W-LOCAL_W-2:0] BASE = 11'h400
) (
    input  logic [ADDR_W-1:0]  addr_i,
    output logic               sel_dev0_o,
    output logic               sel_dev1_o,
    output logic [LOCAL_W-1:0] local_addr_o
);
    localparam int TAG_W = ADDR_W - LOCAL_W - 1;

    mad_pkg::chip_sel_t sel_part;
    mad_pkg::chip_sel_t sel_full;
    mad_pkg::chip_sel_t sel_mux;

    mad_partial_dec u_part (
        .msb_i (addr_i[ADDR_W-1]),
        .sel_o (sel_part)
    );

    mad_full_dec #(
        .TAG_W (TAG_W),
        .BASE  (BASE)
    ) u_full (
        .tag_i  (addr_i[ADDR_W-1:LOCAL_W+1]),
        .bank_i (addr_i[LOCAL_W]),
        .sel_o  (sel_full)
    );

    always_comb begin
        sel_mux = (MODE == mad_pkg::DEC_FULL) ? sel_full : sel_part;
    end

    assign sel_dev0_o   = sel_mux.dev0;
    assign sel_dev1_o   = sel_mux.dev1;
    assign local_addr_o = addr_i[LOCAL_W-1:0];
endmodule

// File: rtl/mem_addr_decoder_chk.sv
module mem_addr_decoder_chk #(
    parameter int ADDR_W = 32,
    parameter int LOCAL_W = 20,
    parameter mad_pkg::dec_mode_e MODE = mad_pkg::DEC_FULL,
    parameter logic [ADDR_W-LOCAL_W-2:0] BASE = 11'h400
) (
    input logic [ADDR_W-1:0]  addr_i,
    input logic               sel_dev0_o,
    input logic               sel_dev1_o,
    input logic [LOCAL_W-1:0] local_addr_o
);
    logic in_window;

    always_comb begin
        in_window = (addr_i[ADDR_W-1:LOCAL_W+1] == BASE);

        // R1 and R9: local address tracks the bus with no delay
        a_r1_local_passthru: assert (local_addr_o == addr_i[LOCAL_W-1:0]);

        a_r8_never_both: assert ($countones({sel_dev1_o, sel_dev0_o}) <= 1);

        if (MODE == mad_pkg::DEC_PARTIAL) begin
            a_r3_one_selected: assert ($countones({sel_dev1_o, sel_dev0_o}) == 1);
            a_r2_msb_steers: assert (sel_dev1_o == addr_i[ADDR_W-1]);
        end else begin
            a_r7_outside_none: assert (in_window || !(sel_dev0_o || sel_dev1_o));
            a_r5_dev0_window: assert (!sel_dev0_o || (in_window && !addr_i[LOCAL_W]));
            a_r6_dev1_window: assert (!sel_dev1_o || (in_window && addr_i[LOCAL_W]));
        end
    end
endmodule

bind mem_addr_decoder mem_addr_decoder_chk #(
    .ADDR_W  (ADDR_W),
    .LOCAL_W (LOCAL_W),
    .MODE    (MODE),
    .BASE    (BASE)
) u_chk (
    .addr_i       (addr_i),
    .sel_dev0_o   (sel_dev0_o),
    .sel_dev1_o   (sel_dev1_o),
    .local_addr_o (local_addr_o)
);

// File: tb/mem_addr_decoder_bench.sv
module mem_addr_decoder_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] addr = 32'h0;

    logic        f_s0, f_s1, p_s0, p_s1;
    logic [19:0] f_loc, p_loc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    mem_addr_decoder #(.MODE(mad_pkg::DEC_FULL), .BASE(11'h400)) u_mem_addr_decoder (
        .addr_i(addr), .sel_dev0_o(f_s0), .sel_dev1_o(f_s1), .local_addr_o(f_loc)
    );

    mem_addr_decoder #(.MODE(mad_pkg::DEC_PARTIAL), .BASE(11'h400)) u_mem_addr_decoder_part (
        .addr_i(addr), .sel_dev0_o(p_s0), .sel_dev1_o(p_s1), .local_addr_o(p_loc)
    );

    // {address, full-mode {sel1,sel0}}
    localparam int NV = 10;
    localparam logic [31:0] V_ADDR [NV] = '{
        32'h8000_0000, 32'h800F_FFFF, 32'h8010_0000, 32'h801F_FFFF, 32'h8020_0000,
        32'h7FFF_FFFF, 32'h0000_0000, 32'hC010_0000, 32'h8012_3456, 32'hFFFF_FFFF
    };
    localparam logic [1:0] V_FSEL [NV] = '{
        2'b01, 2'b01, 2'b10, 2'b10, 2'b00,
        2'b00, 2'b00, 2'b00, 2'b10, 2'b00
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s addr=%h got=%h exp=%h", req, addr, got, exp);
        end
    endtask

    task automatic apply(input logic [31:0] a);
        @(negedge clk);
        addr = a;
        #1;
    endtask

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Reset state: address 0 from time zero
        #1;
        check("R7 reset full", {30'b0, f_s1, f_s0}, 32'h0);
        check("R3 reset partial", {30'b0, p_s1, p_s0}, 32'h1);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            apply(V_ADDR[i]);
            check("R5/R6/R7 full sel", {30'b0, f_s1, f_s0}, {30'b0, V_FSEL[i]});
            check("R1 full local", {12'b0, f_loc}, {12'b0, V_ADDR[i][19:0]});
            check("R2 partial sel", {30'b0, p_s1, p_s0}, {30'b0, V_ADDR[i][31], ~V_ADDR[i][31]});
            check("R1 partial local", {12'b0, p_loc}, {12'b0, V_ADDR[i][19:0]});
            check("R8 full never both", {31'b0, f_s0 & f_s1}, 32'h0);
        end

        // R4: sweep bits 30:20 with fixed low bits and MSB
        for (int m = 0; m < 2; m++) begin
            for (int u = 0; u < 2048; u += 97) begin
                apply({m[0], u[10:0], 20'hA5C3E});
                check("R4 alias sel", {30'b0, p_s1, p_s0}, {30'b0, m[0], ~m[0]});
                check("R4 alias local", {12'b0, p_loc}, 32'h000A_5C3E);
                check("R3 exactly one", {31'b0, p_s0 ^ p_s1}, 32'h1);
            end
        end

        // R5/R6 single-bit misses on the tag
        for (int b = 21; b < 32; b++) begin
            logic [31:0] a;
            a = 32'h8001_2345 ^ (32'h1 << b);
            apply(a);
            check("R7 tag bit miss", {30'b0, f_s1, f_s0}, 32'h0);
        end

        // R9: change address mid-cycle, no clock edge between
        @(posedge clk);
        #1 addr = 32'h8000_0010;
        #1 check("R9 same cycle dev0", {30'b0, f_s1, f_s0}, 32'h1);
        addr = 32'h8010_0020;
        #1 check("R9 same cycle dev1", {30'b0, f_s1, f_s0}, 32'h2);
        check("R9 same cycle local", {12'b0, f_loc}, 32'h20);

        report();
    end
endmodule